// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block turns a group of up to four decoded instructions into renamed instructions in one cycle. Each slot names up to two logical sources and at most one logical destination. Every destination gets a fresh physical register from a free pool. Every source is translated to the physical register that was most recently assigned to its logical register. A source that depends on an earlier slot of the same group takes that slot's new tag instead of the table entry. Alongside the mapping the block keeps a readiness bit per physical register. Two result buses set these bits, and each renamed source reports whether its value is already available.

The outputs are combinational from the current state and the presented group. The mapping, the pool and the readiness bits are updated at the clock edge on which the group is accepted. When the pool cannot cover every destination of the group, the whole group is held back with `in_ready` low. A single return port puts a physical register back into the pool, so that the block can run without a commit stage. After reset, logical register n maps to physical register n, and every physical register below the logical count is ready. The physical registers from the logical count upward start in the free pool.

Top module: `rn_rename4`

## Requirements
- R1: After reset, a source naming logical register n translates to physical tag n with its ready flag set, and `in_ready` is high.
- R2: Each valid slot with `dst_en` set and a nonzero destination gets a distinct free physical tag. Tags are granted lowest-index first, in slot order 0 to 3. A slot that writes nothing shows `pdst` 0.
- R3: A source with no earlier in-group writer translates to the tag last recorded for its logical register by accepted groups.
- R4: A source equal to the destination of an earlier valid writing slot in the same group takes the tag of the nearest such slot, with its ready flag clear.
- R5: When several slots of one group write the same logical register, later groups see the tag of the highest-numbered of those slots.
- R6: Logical register 0 always translates to tag 0 and reads ready. A destination of 0 allocates nothing, and tag 0 is never granted.
- R7: When the writers in the group outnumber the free tags, `in_ready` is low. The mapping, the pool and the readiness bits are then unchanged by the group.
- R8: Granting a tag clears its ready bit, and a valid result-bus tag sets it. A clear and a set in the same cycle leave the bit clear. A source whose tag is on a result bus in the current cycle reads ready.
- R9: `ret_valid` with a nonzero `ret_tag` returns that tag to the pool at the clock edge. A return of tag 0 is ignored.
- R10: `out_valid` equals `in_valid` and `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group is presented |
| slot_valid | input | 4 | Per-slot valid |
| src1 | input | 4x5 | First logical source per slot |
| src2 | input | 4x5 | Second logical source per slot |
| dst | input | 4x5 | Logical destination per slot |
| dst_en | input | 4 | Slot writes a destination |
| in_ready | output | 1 | Pool can cover the group |
| out_valid | output | 1 | Group accepted this cycle |
| psrc1 | output | 4x6 | Physical tag of first source |
| psrc2 | output | 4x6 | Physical tag of second source |
| pdst | output | 4x6 | Granted physical destination |
| src1_rdy | output | 4 | First source value available |
| src2_rdy | output | 4 | Second source value available |
| bus_valid | input | 2 | Result-bus broadcast valid |
| bus_tag | input | 2x6 | Result-bus physical tags |
| ret_valid | input | 1 | Return a tag to the pool |
| ret_tag | input | 6 | Tag being returned |

## Verification
A directed group places a writer of r5 ahead of a reader and a second writer of r5, with a reader of the second writer in slot 3. This separates nearest-writer forwarding from a table read, and youngest-wins table update from oldest-wins. Random groups drawn mostly from logical registers 0 to 7 make in-group collisions frequent. One phase gives no returns, so the pool drains and stalls appear. A later phase returns often, so allocation picks from a scattered pool. Result-bus tags cover ready and pending registers alike, and sometimes hit a register granted in the same cycle, which tells apart the ordering of set and clear.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_GROUP = 4;
    localparam int RN_NLOG  = 32;
    localparam int RN_NPHYS = 64;
    localparam int RN_NBUS  = 2;

    // a slot consumes a physical register only when it really writes
    function automatic logic slot_writes(input logic vld, input logic en, input logic [31:0] d);
        return vld && en && (d != 32'd0);
    endfunction
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NPHYS = rn_pkg::RN_NPHYS,
    parameter int NLOG  = rn_pkg::RN_NLOG,
    parameter int GW    = rn_pkg::RN_GROUP,
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(NPHYS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GW-1:0]          req,
    input  logic                   commit,
    input  logic                   ret_v,
    input  logic [PW-1:0]          ret_tag,
    output logic [GW-1:0][PW-1:0]  grant,
    output logic                   enough
);
    logic [NPHYS-1:0] free_q;
    logic [NPHYS-1:0] avail;
    logic [CW-1:0]    have;
    logic [CW-1:0]    need;

    always_comb begin
        logic found;
        avail = free_q;
        have  = '0;
        need  = '0;
        for (int p = 0; p < NPHYS; p++) have = have + CW'(free_q[p]);
        for (int j = 0; j < GW; j++) begin
            grant[j] = '0;
            found    = 1'b0;
            if (req[j]) begin
                need = need + CW'(1);
                for (int p = 0; p < NPHYS; p++) begin
                    if (!found && avail[p]) begin
                        grant[j] = PW'(p);
                        avail[p] = 1'b0;
                        found    = 1'b1;
                    end
                end
            end
        end
        enough = (need <= have);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NLOG);
        end else begin
            if (commit) free_q <= avail | ((ret_v && ret_tag != '0) ? (NPHYS'(1) << ret_tag) & ~(free_q ^ avail) : '0);
            else if (ret_v && ret_tag != '0) free_q[ret_tag] <= 1'b1;
        end
    end

    assert_return_frees_R9: assert property (@(posedge clk) disable iff (rst)
        ret_v && ret_tag != '0 && !free_q[ret_tag] |=> free_q[$past(ret_tag)]);

    generate
        for (genvar j = 0; j < GW; j++) begin : g_chk
            assert_grant_taken_R2: assert property (@(posedge clk) disable iff (rst)
                commit && req[j] |=> !free_q[$past(grant[j])]);
        end
    endgenerate
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NLOG  = rn_pkg::RN_NLOG,
    parameter int NPHYS = rn_pkg::RN_NPHYS,
    parameter int GW    = rn_pkg::RN_GROUP,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GW-1:0]          we,
    input  logic [GW-1:0][LW-1:0]  wlog,
    input  logic [GW-1:0][PW-1:0]  wtag,
    input  logic [GW-1:0][LW-1:0]  ra1,
    input  logic [GW-1:0][LW-1:0]  ra2,
    output logic [GW-1:0][PW-1:0]  rt1,
    output logic [GW-1:0][PW-1:0]  rt2
);
    logic [NLOG-1:0][PW-1:0] map_q;

    always_comb begin
        for (int j = 0; j < GW; j++) begin
            rt1[j] = map_q[ra1[j]];
            rt2[j] = map_q[ra2[j]];
        end
    end

    // slot order: a later slot's write lands last, so the youngest wins
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < NLOG; l++) map_q[l] <= PW'(l);
        end else begin
            for (int j = 0; j < GW; j++)
                if (we[j]) map_q[wlog[j]] <= wtag[j];
        end
    end

    assert_idle_keeps_map_R7: assert property (@(posedge clk) disable iff (rst)
        !(|we) |=> $stable(map_q));
    assert_last_writer_wins_R5: assert property (@(posedge clk) disable iff (rst)
        we[GW-1] |=> map_q[$past(wlog[GW-1])] == $past(wtag[GW-1]));
endmodule

// File: rtl/rn_ready_table.sv
module rn_ready_table #(
    parameter int NPHYS = rn_pkg::RN_NPHYS,
    parameter int NLOG  = rn_pkg::RN_NLOG,
    parameter int GW    = rn_pkg::RN_GROUP,
    parameter int NBUS  = rn_pkg::RN_NBUS,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NBUS-1:0]          bus_v,
    input  logic [NBUS-1:0][PW-1:0]  bus_tag,
    input  logic [GW-1:0]            clr,
    input  logic [GW-1:0][PW-1:0]    clr_tag,
    input  logic [GW-1:0][PW-1:0]    q1,
    input  logic [GW-1:0][PW-1:0]    q2,
    output logic [GW-1:0]            r1,
    output logic [GW-1:0]            r2
);
    logic [NPHYS-1:0] rdy_q;

    function automatic logic on_bus(input logic [PW-1:0] t, input logic [NBUS-1:0] v,
                                    input logic [NBUS-1:0][PW-1:0] bt);
        logic hit = 1'b0;
        for (int b = 0; b < NBUS; b++) hit |= v[b] && (bt[b] == t);
        return hit;
    endfunction

    always_comb begin
        for (int j = 0; j < GW; j++) begin
            r1[j] = rdy_q[q1[j]] | on_bus(q1[j], bus_v, bus_tag);
            r2[j] = rdy_q[q2[j]] | on_bus(q2[j], bus_v, bus_tag);
        end
    end

    // clears placed after sets: a fresh allocation dominates a stale broadcast
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPHYS; p++) rdy_q[p] <= (p < NLOG);
        end else begin
            for (int b = 0; b < NBUS; b++) if (bus_v[b]) rdy_q[bus_tag[b]] <= 1'b1;
            for (int j = 0; j < GW; j++) if (clr[j]) rdy_q[clr_tag[j]] <= 1'b0;
        end
    end

    generate
        for (genvar j = 0; j < GW; j++) begin : g_clr
            assert_alloc_clears_R8: assert property (@(posedge clk) disable iff (rst)
                clr[j] |=> !rdy_q[$past(clr_tag[j])]);
        end
        for (genvar b = 0; b < NBUS; b++) begin : g_set
            assert_bus_sets_R8: assert property (@(posedge clk) disable iff (rst)
                bus_v[b] && !(|clr) |=> rdy_q[$past(bus_tag[b])]);
        end
    endgenerate
endmodule

// File: rtl/rn_rename4.sv
module rn_rename4 #(
    parameter int GW    = rn_pkg::RN_GROUP,
    parameter int NLOG  = rn_pkg::RN_NLOG,
    parameter int NPHYS = rn_pkg::RN_NPHYS,
    parameter int NBUS  = rn_pkg::RN_NBUS,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [GW-1:0]            slot_valid,
    input  logic [GW-1:0][LW-1:0]    src1,
    input  logic [GW-1:0][LW-1:0]    src2,
    input  logic [GW-1:0][LW-1:0]    dst,
    input  logic [GW-1:0]            dst_en,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic [GW-1:0][PW-1:0]    psrc1,
    output logic [GW-1:0][PW-1:0]    psrc2,
    output logic [GW-1:0][PW-1:0]    pdst,
    output logic [GW-1:0]            src1_rdy,
    output logic [GW-1:0]            src2_rdy,
    input  logic [NBUS-1:0]          bus_valid,
    input  logic [NBUS-1:0][PW-1:0]  bus_tag,
    input  logic                     ret_valid,
    input  logic [PW-1:0]            ret_tag
);
    typedef struct packed {
        logic [PW-1:0] tag;
        logic          rdy;
    } src_map_t;

    logic [GW-1:0]           writes;
    logic [GW-1:0][PW-1:0]   grant;
    logic [GW-1:0][PW-1:0]   mt1, mt2;
    logic [GW-1:0]           tr1, tr2;
    logic                    enough;
    logic                    fire;

    always_comb begin
        for (int j = 0; j < GW; j++)
            writes[j] = rn_pkg::slot_writes(slot_valid[j], dst_en[j], 32'(dst[j]));
    end

    assign in_ready  = enough;
    assign fire      = in_valid && enough;
    assign out_valid = fire;

    rn_free_list #(.NPHYS(NPHYS), .NLOG(NLOG), .GW(GW)) u_free (
        .clk(clk), .rst(rst), .req(writes), .commit(fire),
        .ret_v(ret_valid), .ret_tag(ret_tag), .grant(grant), .enough(enough)
    );

    rn_map_table #(.NLOG(NLOG), .NPHYS(NPHYS), .GW(GW)) u_map (
        .clk(clk), .rst(rst), .we(writes & {GW{fire}}), .wlog(dst), .wtag(grant),
        .ra1(src1), .ra2(src2), .rt1(mt1), .rt2(mt2)
    );

    rn_ready_table #(.NPHYS(NPHYS), .NLOG(NLOG), .GW(GW), .NBUS(NBUS)) u_rdy (
        .clk(clk), .rst(rst), .bus_v(bus_valid), .bus_tag(bus_tag),
        .clr(writes & {GW{fire}}), .clr_tag(grant),
        .q1(mt1), .q2(mt2), .r1(tr1), .r2(tr2)
    );

    // nearest older writer in the group overrides the table; r0 is pinned
    function automatic src_map_t resolve(input int slot, input logic [LW-1:0] s,
                                         input logic [PW-1:0] tbl_tag, input logic tbl_rdy,
                                         input logic [GW-1:0] wr, input logic [GW-1:0][LW-1:0] d,
                                         input logic [GW-1:0][PW-1:0] g);
        src_map_t r;
        r.tag = tbl_tag;
        r.rdy = tbl_rdy;
        for (int k = 0; k < GW; k++) begin
            if (k < slot && wr[k] && d[k] == s) begin
                r.tag = g[k];
                r.rdy = 1'b0;
            end
        end
        if (s == '0) begin
            r.tag = '0;
            r.rdy = 1'b1;
        end
        return r;
    endfunction

    generate
        for (genvar j = 0; j < GW; j++) begin : g_slot
            src_map_t a, b;
            always_comb begin
                a = resolve(j, src1[j], mt1[j], tr1[j], writes, dst, grant);
                b = resolve(j, src2[j], mt2[j], tr2[j], writes, dst, grant);
                psrc1[j]    = a.tag;
                src1_rdy[j] = a.rdy;
                psrc2[j]    = b.tag;
                src2_rdy[j] = b.rdy;
                pdst[j]     = writes[j] ? grant[j] : '0;
            end

            assert_no_tag_zero_R6: assert property (@(posedge clk) disable iff (rst)
                out_valid && writes[j] |-> pdst[j] != '0);
            if (j > 0) begin : g_fwd
                assert_forward_prev_R4: assert property (@(posedge clk) disable iff (rst)
                    writes[j-1] && slot_valid[j] && src1[j] == dst[j-1]
                    |-> psrc1[j] == pdst[j-1] && !src1_rdy[j]);
            end
        end
    endgenerate

    assert_valid_gated_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_valid && in_ready);
endmodule

// File: tb/rn_rename4_bench.sv
`timescale 1ns/1ps
module rn_rename4_bench;
    localparam int GW = 4, NL = 32, NP = 64, NB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic in_valid;
    logic [GW-1:0] slot_valid, dst_en;
    logic [GW-1:0][4:0] src1, src2, dst;
    logic in_ready, out_valid;
    logic [GW-1:0][5:0] psrc1, psrc2, pdst;
    logic [GW-1:0] src1_rdy, src2_rdy;
    logic [NB-1:0] bus_valid;
    logic [NB-1:0][5:0] bus_tag;
    logic ret_valid;
    logic [5:0] ret_tag;

    rn_rename4 u_rn_rename4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .slot_valid(slot_valid),
        .src1(src1), .src2(src2), .dst(dst), .dst_en(dst_en),
        .in_ready(in_ready), .out_valid(out_valid), .psrc1(psrc1), .psrc2(psrc2),
        .pdst(pdst), .src1_rdy(src1_rdy), .src2_rdy(src2_rdy),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model state
    int mmap[NL];
    bit mrdy[NP];
    bit mfree[NP];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit wr(int j);
        return slot_valid[j] && dst_en[j] && dst[j] != 0;
    endfunction

    function automatic bit busy(int t);
        for (int b = 0; b < NB; b++) if (bus_valid[b] && bus_tag[b] == t) return 1;
        return 0;
    endfunction

    // compare this cycle's outputs with the model, then advance the model
    task automatic model_step();
        int need = 0, have = 0;
        int g[GW];
        bit fire;
        bit used[NP];
        for (int p = 0; p < NP; p++) begin have += mfree[p]; used[p] = 0; end
        for (int j = 0; j < GW; j++) begin
            g[j] = 0;
            if (wr(j)) begin
                need++;
                for (int p = 0; p < NP; p++)
                    if (mfree[p] && !used[p]) begin g[j] = p; used[p] = 1; break; end
            end
        end
        fire = in_valid && (need <= have);
        chk("R7", "in_ready", in_ready, need <= have);
        chk("R10", "out_valid", out_valid, fire);
        if (fire) begin
            for (int j = 0; j < GW; j++) begin
                if (!slot_valid[j]) continue;
                for (int s = 0; s < 2; s++) begin
                    int l = (s == 0) ? int'(src1[j]) : int'(src2[j]);
                    int et = mmap[l];
                    int er = mrdy[et] || busy(et);
                    string rq = "R3";
                    for (int k = 0; k < j; k++)
                        if (wr(k) && dst[k] == l) begin et = g[k]; er = 0; rq = "R4"; end
                    if (l == 0) begin et = 0; er = 1; rq = "R6"; end
                    if (s == 0) begin
                        chk(rq, $sformatf("psrc1[%0d]", j), psrc1[j], et);
                        chk(rq == "R3" ? "R8" : rq, $sformatf("src1_rdy[%0d]", j), src1_rdy[j], er);
                    end else begin
                        chk(rq, $sformatf("psrc2[%0d]", j), psrc2[j], et);
                        chk(rq == "R3" ? "R8" : rq, $sformatf("src2_rdy[%0d]", j), src2_rdy[j], er);
                    end
                end
                chk("R2", $sformatf("pdst[%0d]", j), pdst[j], g[j]);
            end
        end
        // next state
        if (ret_valid && ret_tag != 0) mfree[ret_tag] = 1;
        for (int b = 0; b < NB; b++) if (bus_valid[b]) mrdy[bus_tag[b]] = 1;
        if (fire)
            for (int j = 0; j < GW; j++)
                if (wr(j)) begin mfree[g[j]] = 0; mmap[dst[j]] = g[j]; mrdy[g[j]] = 0; end
    endtask

    task automatic idle_inputs();
        in_valid = 0; slot_valid = '0; dst_en = '0;
        src1 = '0; src2 = '0; dst = '0;
        bus_valid = '0; bus_tag = '0; ret_valid = 0; ret_tag = '0;
    endtask

    function automatic logic [4:0] pick_log();
        return ($urandom_range(0, 9) < 7) ? 5'($urandom_range(0, 7)) : 5'($urandom_range(0, 31));
    endfunction

    initial begin
        idle_inputs();
        for (int l = 0; l < NL; l++) mmap[l] = l;
        for (int p = 0; p < NP; p++) begin mrdy[p] = (p < NL); mfree[p] = (p >= NL); end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // reset state: identity mapping, all ready
        src1 = {5'd31, 5'd17, 5'd9, 5'd1};
        src2 = {5'd0, 5'd30, 5'd2, 5'd3};
        slot_valid = 4'hF; in_valid = 1;
        #1;
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "psrc1[3]", psrc1[3], 31);
        chk("R1", "src1_rdy", src1_rdy, 4'hF);
        chk("R1", "src2_rdy", src2_rdy, 4'hF);
        model_step();

        // in-group dependencies, repeated destination
        @(negedge clk);
        src1 = {5'd5, 5'd0, 5'd5, 5'd5};
        src2 = '0;
        dst  = {5'd7, 5'd0, 5'd5, 5'd5};
        dst_en = 4'hF;
        #1;
        chk("R2", "pdst[0]", pdst[0], 32);
        chk("R4", "psrc1[1]", psrc1[1], 32);
        chk("R4", "src1_rdy[1]", src1_rdy[1], 0);
        chk("R6", "pdst[2]", pdst[2], 0);
        chk("R4", "psrc1[3]", psrc1[3], 33);
        chk("R2", "pdst[3]", pdst[3], 34);
        model_step();

        @(negedge clk);
        src1 = {5'd7, 5'd7, 5'd5, 5'd5};
        dst_en = '0;
        ret_valid = 1; ret_tag = 0;
        #1;
        chk("R5", "psrc1[0]", psrc1[0], 33);
        chk("R3", "psrc1[2]", psrc1[2], 34);
        chk("R8", "src1_rdy[0]", src1_rdy[0], 0);
        model_step();

        // broadcast of r5's tag makes it ready
        @(negedge clk);
        ret_valid = 0;
        bus_valid = 2'b10; bus_tag[1] = 6'd33;
        #1;
        chk("R8", "src1_rdy[0] bus bypass", src1_rdy[0], 1);
        model_step();

        // random phases: drain (no returns), then heavy returns
        for (int c = 0; c < 4000; c++) begin
            int rp = (c % 400 < 150) ? 0 : 7;
            @(negedge clk);
            in_valid = ($urandom_range(0, 9) < 8);
            for (int j = 0; j < GW; j++) begin
                slot_valid[j] = ($urandom_range(0, 9) < 8);
                dst_en[j] = ($urandom_range(0, 9) < 7);
                src1[j] = pick_log(); src2[j] = pick_log(); dst[j] = pick_log();
            end
            for (int b = 0; b < NB; b++) begin
                bus_valid[b] = $urandom_range(0, 1);
                bus_tag[b] = 6'($urandom_range(0, 63));
            end
            ret_valid = ($urandom_range(0, 9) < rp);
            ret_tag = 6'($urandom_range(0, 63));
            #1;
            model_step();
        end
        @(negedge clk);
        idle_inputs();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule